// File: doc/BRIEF.md
# Lowest-Set-Bit Mask Generator Unit

This execution unit turns a source operand into a mask that is one in every bit from bit 0 up to and including the lowest one bit of the source. It also produces the arithmetic flags that go with the operation. The operand is 32 or 64 bits wide. The width follows from a 64-bit-mode input and a width-select bit taken from the instruction prefix. A vector-length bit that is set makes the operation illegal: the unit then raises an invalid-opcode signal and writes nothing.

The unit takes one operation for each cycle in which `in_valid_i` is high. The result, the flags, their write enables and the exception signal are registered and appear one cycle later, together with `out_valid_o`. Between operations the registered result holds its value. The auxiliary-carry and parity flags are undefined for this operation, so their shared write enable stays low.

Top module: `lsbm_unit`

## Requirements
- R1: In a legal operation, `dest_o` equals S XOR (S − 1), computed at the operand width, where S is the source truncated to that width. The result is therefore a nonzero run of ones that starts at bit 0.
- R2: A source that is zero at the operand width gives all ones at that width in `dest_o` and sets `flag_cf_o` to 1.
- R3: A source that is nonzero at the operand width gives `flag_cf_o` = 0.
- R4: `flag_sf_o` equals the top bit of the result at the operand width: bit 63 for 64-bit operations and bit 31 for 32-bit operations.
- R5: `flag_zf_o` and `flag_of_o` are 0 in every output.
- R6: The operand width is 64 bits only when `long_mode_i` and `wide_sel_i` are both 1. In every other case it is 32 bits: source bits 63:32 are ignored and `dest_o[63:32]` is 0. Outside 64-bit mode `wide_sel_i` has no effect.
- R7: When `vlen_i` is 1 in an accepted operation, the output has `ud_o` = 1, `dest_we_o` = 0, `flag_we_o` = 0, and `dest_o` and all flags are 0. A legal operation gives `ud_o` = 0 with both write enables at 1.
- R8: `out_valid_o` is high exactly in the cycle after each cycle with `in_valid_i` high. In cycles with no input strobe the other outputs keep their previous values.
- R9: `flag_undef_we_o`, the write enable for the auxiliary-carry and parity flags, is 0 at all times.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| src_i | input | 64 | Source operand |
| long_mode_i | input | 1 | Unit is in 64-bit mode |
| wide_sel_i | input | 1 | Prefix width-select bit |
| vlen_i | input | 1 | Prefix vector-length bit |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| dest_o | output | 64 | Mask result |
| dest_we_o | output | 1 | Destination write enable |
| flag_sf_o | output | 1 | Sign flag |
| flag_zf_o | output | 1 | Zero flag (always 0) |
| flag_cf_o | output | 1 | Carry flag: source was zero |
| flag_of_o | output | 1 | Overflow flag (always 0) |
| flag_we_o | output | 1 | Write enable for SF, ZF, CF and OF |
| flag_undef_we_o | output | 1 | Write enable for AF and PF (always 0) |
| ud_o | output | 1 | Invalid-opcode exception |

## Verification
The properties assume that the strobe, source and mode inputs are driven to known values at every clock edge after reset. They also assume that the inputs are held at 0 during reset, because the width and latency checks look one cycle back. The bench changes inputs only on falling edges, drives all of them to 0 while idle and during reset, and lowers the strobe after every operation. This lets the hold checks see quiet cycles. The stimulus covers every combination of the mode and width-select bits, so the width assumptions are exercised both ways.

// File: rtl/lsbm_pkg.sv
package lsbm_pkg;

    localparam int unsigned XLEN = 64;
    localparam int unsigned NLEN = 32;
    localparam int unsigned NUM_W = 2;

    typedef enum logic {
        OPW_NARROW = 1'b0,
        OPW_WIDE   = 1'b1
    } opw_e;

    typedef struct packed {
        logic sf;
        logic zf;
        logic cf;
        logic of;
    } flags_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] dest;
        logic            dest_we;
        flags_t          flags;
        logic            flag_we;
        logic            ud;
    } res_t;

endpackage

// File: rtl/lsbm_width_sel.sv
module lsbm_width_sel
    import lsbm_pkg::*;
(
    input  logic long_mode_i,
    input  logic wide_sel_i,
    output opw_e opw_o
);

    // The prefix width bit only counts in 64-bit mode.
    always_comb begin
        if (long_mode_i && wide_sel_i) begin
            opw_o = OPW_WIDE;
        end else begin
            opw_o = OPW_NARROW;
        end
    end

endmodule

// File: rtl/lsbm_mask_core.sv
module lsbm_mask_core #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] src_i,
    output logic [W-1:0] mask_o,
    output logic         zero_o,
    output logic         msb_o
);

    logic [W-1:0] dec;

    // Borrow ripples up to the lowest one bit; the XOR keeps exactly those bits.
    always_comb begin
        dec    = src_i - W'(1);
        mask_o = src_i ^ dec;
        zero_o = (src_i == '0);
        msb_o  = mask_o[W-1];
    end

endmodule

// File: rtl/lsbm_flag_gen.sv
module lsbm_flag_gen
    import lsbm_pkg::*;
(
    input  opw_e             opw_i,
    input  logic [NUM_W-1:0] zero_i,
    input  logic [NUM_W-1:0] msb_i,
    output flags_t           flags_o
);

    logic sel_zero;
    logic sel_msb;

    always_comb begin
        sel_zero = (opw_i == OPW_WIDE) ? zero_i[1] : zero_i[0];
        sel_msb  = (opw_i == OPW_WIDE) ? msb_i[1]  : msb_i[0];
        flags_o.sf = sel_msb;
        flags_o.zf = 1'b0;
        flags_o.cf = sel_zero;
        flags_o.of = 1'b0;
    end

endmodule

// File: rtl/lsbm_unit.sv
module lsbm_unit
    import lsbm_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        in_valid_i,
    input  logic [63:0] src_i,
    input  logic        long_mode_i,
    input  logic        wide_sel_i,
    input  logic        vlen_i,
    output logic        out_valid_o,
    output logic [63:0] dest_o,
    output logic        dest_we_o,
    output logic        flag_sf_o,
    output logic        flag_zf_o,
    output logic        flag_cf_o,
    output logic        flag_of_o,
    output logic        flag_we_o,
    output logic        flag_undef_we_o,
    output logic        ud_o
);

    opw_e             opw;
    logic [XLEN-1:0]  mask_pad [NUM_W];
    logic [NUM_W-1:0] zero_v;
    logic [NUM_W-1:0] msb_v;
    flags_t           flags_c;
    res_t             res_d;
    res_t             res_q;

    lsbm_width_sel i_width_sel (
        .long_mode_i (long_mode_i),
        .wide_sel_i  (wide_sel_i),
        .opw_o       (opw)
    );

    // One mask datapath for each supported operand width.
    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int unsigned W = (g == 0) ? NLEN : XLEN;
        logic [W-1:0] mask_w;

        lsbm_mask_core #(.W(W)) i_core (
            .src_i  (src_i[W-1:0]),
            .mask_o (mask_w),
            .zero_o (zero_v[g]),
            .msb_o  (msb_v[g])
        );

        assign mask_pad[g] = XLEN'(mask_w);
    end

    lsbm_flag_gen i_flag_gen (
        .opw_i   (opw),
        .zero_i  (zero_v),
        .msb_i   (msb_v),
        .flags_o (flags_c)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (in_valid_i) begin
            res_d.valid = 1'b1;
            if (vlen_i) begin
                res_d.dest    = '0;
                res_d.dest_we = 1'b0;
                res_d.flags   = '0;
                res_d.flag_we = 1'b0;
                res_d.ud      = 1'b1;
            end else begin
                res_d.dest    = (opw == OPW_WIDE) ? mask_pad[1] : mask_pad[0];
                res_d.dest_we = 1'b1;
                res_d.flags   = flags_c;
                res_d.flag_we = 1'b1;
                res_d.ud      = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid_o     = res_q.valid;
    assign dest_o          = res_q.dest;
    assign dest_we_o       = res_q.dest_we;
    assign flag_sf_o       = res_q.flags.sf;
    assign flag_zf_o       = res_q.flags.zf;
    assign flag_cf_o       = res_q.flags.cf;
    assign flag_of_o       = res_q.flags.of;
    assign flag_we_o       = res_q.flag_we;
    assign flag_undef_we_o = 1'b0;
    assign ud_o            = res_q.ud;

endmodule

// File: rtl/lsbm_unit_chk.sv
module lsbm_unit_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_valid_i,
    input logic [63:0] src_i,
    input logic        long_mode_i,
    input logic        wide_sel_i,
    input logic        vlen_i,
    input logic        out_valid_o,
    input logic [63:0] dest_o,
    input logic        dest_we_o,
    input logic        flag_sf_o,
    input logic        flag_zf_o,
    input logic        flag_cf_o,
    input logic        flag_of_o,
    input logic        flag_we_o,
    input logic        ud_o
);

    p_mask_shape_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && dest_we_o |-> (dest_o != '0) && ((dest_o & (dest_o + 64'd1)) == '0));

    p_zero_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && !vlen_i && long_mode_i && wide_sel_i && (src_i == '0)
        |=> flag_cf_o && (&dest_o));

    p_nonzero_cf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && !vlen_i && (src_i[31:0] != '0) |=> !flag_cf_o);

    p_sign_msb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && flag_we_o
        |-> flag_sf_o == ($past(long_mode_i && wide_sel_i) ? dest_o[63] : dest_o[31]));

    p_zf_of_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> !flag_zf_o && !flag_of_o);

    p_narrow_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && !vlen_i && !(long_mode_i && wide_sel_i) |=> dest_o[63:32] == '0);

    p_ud_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && vlen_i |=> ud_o && !dest_we_o && !flag_we_o);

    p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o && $stable(dest_o));

endmodule

bind lsbm_unit lsbm_unit_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .src_i       (src_i),
    .long_mode_i (long_mode_i),
    .wide_sel_i  (wide_sel_i),
    .vlen_i      (vlen_i),
    .out_valid_o (out_valid_o),
    .dest_o      (dest_o),
    .dest_we_o   (dest_we_o),
    .flag_sf_o   (flag_sf_o),
    .flag_zf_o   (flag_zf_o),
    .flag_cf_o   (flag_cf_o),
    .flag_of_o   (flag_of_o),
    .flag_we_o   (flag_we_o),
    .ud_o        (ud_o)
);

// File: tb/test_lsbm_unit.sv
`timescale 1ns/1ps
module test_lsbm_unit;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [63:0] src_i = '0;
    logic        long_mode_i = 1'b0;
    logic        wide_sel_i = 1'b0;
    logic        vlen_i = 1'b0;
    logic        out_valid_o;
    logic [63:0] dest_o;
    logic        dest_we_o;
    logic        flag_sf_o;
    logic        flag_zf_o;
    logic        flag_cf_o;
    logic        flag_of_o;
    logic        flag_we_o;
    logic        flag_undef_we_o;
    logic        ud_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    lsbm_unit i_lsbm_unit (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and compare against a model built from the requirements.
    task automatic run_op(input logic [63:0] s, input logic lm, input logic ws, input logic vl);
        logic        wide;
        logic [63:0] sv;
        logic [63:0] m;
        wide = lm && ws;
        sv   = wide ? s : {32'h0, s[31:0]};
        m    = sv ^ (sv - 64'd1);
        if (!wide) m[63:32] = '0;
        @(negedge clk_i);
        in_valid_i = 1'b1; src_i = s; long_mode_i = lm; wide_sel_i = ws; vlen_i = vl;
        @(negedge clk_i);
        in_valid_i = 1'b0; src_i = '0; long_mode_i = 1'b0; wide_sel_i = 1'b0; vlen_i = 1'b0;
        chk("R8 out_valid", 64'(out_valid_o), 64'd1);
        chk("R5 zf/of", {62'd0, flag_zf_o, flag_of_o}, 64'd0);
        chk("R9 undef we", 64'(flag_undef_we_o), 64'd0);
        if (vl) begin
            chk("R7 ud", 64'(ud_o), 64'd1);
            chk("R7 write enables", {62'd0, dest_we_o, flag_we_o}, 64'd0);
            chk("R7 dest", dest_o, 64'd0);
            chk("R7 flags", {62'd0, flag_sf_o, flag_cf_o}, 64'd0);
        end else begin
            chk("R1 dest", dest_o, m);
            chk("R7 legal enables", {61'd0, ud_o, dest_we_o, flag_we_o}, 64'd3);
            if (sv == '0) chk("R2 cf", 64'(flag_cf_o), 64'd1);
            else          chk("R3 cf", 64'(flag_cf_o), 64'd0);
            chk("R4 sf", 64'(flag_sf_o), 64'(wide ? m[63] : m[31]));
            if (!wide) chk("R6 upper zero", {32'h0, dest_o[63:32]}, 64'd0);
        end
    endtask

    task automatic t_reset();
        chk("R10 out_valid", 64'(out_valid_o), 64'd0);
        chk("R10 dest", dest_o, 64'd0);
        chk("R10 flags/enables",
            {56'd0, dest_we_o, flag_sf_o, flag_zf_o, flag_cf_o, flag_of_o, flag_we_o, flag_undef_we_o, ud_o},
            64'd0);
    endtask

    task automatic t_basic();
        run_op(64'h0000_0000_0000_0028, 1'b1, 1'b1, 1'b0);
        run_op(64'h0000_0000_0000_0028, 1'b1, 1'b0, 1'b0);
        run_op(64'hF0F0_0000_0001_0000, 1'b1, 1'b1, 1'b0);
        run_op(64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1, 1'b0);
        run_op(64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero_one_ones();
        run_op(64'h0, 1'b1, 1'b1, 1'b0);                      // R2 wide
        run_op(64'h0, 1'b0, 1'b0, 1'b0);                      // R2 narrow
        run_op(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b0);    // R6 narrow low half zero
        run_op(64'h1, 1'b1, 1'b1, 1'b0);
        run_op(64'h1, 1'b0, 1'b0, 1'b0);
        run_op('1, 1'b1, 1'b1, 1'b0);
        run_op('1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_single_bits();
        for (int b = 0; b < 64; b++) begin
            run_op(64'd1 << b, 1'b1, 1'b1, 1'b0);
            run_op(64'd1 << b, 1'b1, 1'b0, 1'b0);
        end
    endtask

    // R6: the width bit has no effect outside 64-bit mode
    task automatic t_mode_ignore();
        run_op(64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b0);
        run_op(64'h0000_0001_8000_0000, 1'b0, 1'b1, 1'b0);
        run_op(64'h0000_0001_8000_0000, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_vlen();
        run_op(64'h0, 1'b1, 1'b1, 1'b1);
        run_op(64'h40, 1'b0, 1'b0, 1'b1);
    endtask

    // R8: outputs hold and valid drops when no strobe arrives
    task automatic t_idle_hold();
        logic [63:0] last;
        run_op(64'h0000_0000_0000_0300, 1'b1, 1'b1, 1'b0);
        last = dest_o;
        @(negedge clk_i);
        src_i = 64'h5; long_mode_i = 1'b1; wide_sel_i = 1'b1;
        @(negedge clk_i);
        chk("R8 idle valid", 64'(out_valid_o), 64'd0);
        chk("R8 idle hold", dest_o, last);
        src_i = '0; long_mode_i = 1'b0; wide_sel_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_basic();
        t_zero_one_ones();
        t_single_bits();
        t_mode_ignore();
        t_vlen();
        t_idle_hold();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule